// File: doc/BRIEF.md
# Integer ALU with Condition Codes

This block is the purely combinational integer execution stage of a load/store RISC core. Each cycle it receives two 32-bit operands, a 6-bit operation code, the current four condition flags and the current multiply-step register (Y). It returns the 32-bit result, the next flag values with a flag write strobe, a tag-overflow trap request, the next Y value with its own write strobe, and an illegal-operation indication. The register file, operand fetch, trap sequencing and any multi-cycle multiply or divide sit outside it.

It covers add and subtract with and without carry, six logical operations (three plain, three with the second operand inverted), three shifts, tagged add with an optional trapping form, and the single-step multiply that shifts Y. When the trapping tagged add detects an error, or when the operation does not set flags, the flags pass through unchanged and the write strobe stays low. The surrounding pipeline registers the outputs and uses the strobes to decide what to commit.

The flag bus is ordered {N, Z, V, C}: bit 3 is N, bit 2 is Z, bit 1 is V, bit 0 is C.

Top module: `iu_alu`

## Requirements
- R1: Codes 0x00, 0x04, 0x08 and 0x0C give a+b, a-b, a+b+C and a-b-C, where C is bit 0 of `flags_in`; adding 0x10 to any of them gives the same result.
- R2: Whenever `flags_we` is 1, flag bit 3 (N) equals bit 31 of `result` and flag bit 2 (Z) is 1 exactly when `result` is zero.
- R3: For flag-setting additions (0x10, 0x18, 0x20, 0x24) V is bit 31 of (a&b&~r)|(~a&~b&r) and C is bit 31 of (a&b)|((a|b)&~r), with a and b the addends and r the sum.
- R4: For flag-setting subtractions (0x14, 0x1C) V is bit 31 of (a&~b&~r)|(~a&b&r) and C is bit 31 of (~a&b)|((~a|b)&r).
- R5: Codes 0x01 and, 0x02 or, 0x03 xor, 0x05 a&~b, 0x06 a|~b, 0x07 a^~b; their forms plus 0x10 also write flags with V and C cleared.
- R6: Operations that do not set flags (codes below 0x10, shifts, trapping tagged add) hold `flags_we` at 0 and drive `flags_out` equal to `flags_in`.
- R7: Tagged add 0x20 returns a+b and writes flags, with V also set when bits 1:0 of either operand are nonzero; it never requests a trap.
- R8: Trapping tagged add 0x22 returns a+b; if the add overflows or either operand has nonzero bits 1:0, `tag_trap` is 1 and the flags are neither written nor changed, otherwise flags are written with V=0.
- R9: Codes 0x25, 0x26 and 0x27 shift a left logically, right logically and right arithmetically by b[4:0]; bits 31:5 of b have no effect.
- R10: Multiply step 0x24 adds {N xor V, a[31:1]} to (Y[0] ? b : 0), writes flags as an add, and sets next Y to {a[0], Y[31:1]}.
- R11: `y_we` is 1 only for 0x24; otherwise `y_out` equals `y_in`.
- R12: Any other code sets `illegal`, drives `result` to zero and holds `flags_we`, `y_we` and `tag_trap` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 6 | Operation select |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand or immediate |
| flags_in | input | 4 | Current flags {N,Z,V,C} |
| y_in | input | 32 | Current multiply-step register |
| result | output | 32 | Operation result |
| flags_out | output | 4 | Next flags {N,Z,V,C} |
| flags_we | output | 1 | Flag write strobe |
| tag_trap | output | 1 | Tag-overflow trap request |
| y_out | output | 32 | Next multiply-step register |
| y_we | output | 1 | Multiply-step register write strobe |
| illegal | output | 1 | Unrecognised operation code |

## Verification
The embedded checks assume that every input is a settled two-state value when they evaluate; they do not depend on any opcode being legal, so every 6-bit code is allowed. The stimulus drives only known values, one full vector at a time after a clock edge, and compares on the opposite edge. Operands come from the four corner values 0, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF in all pairings, plus seeded random values. Flags and Y are random, so both carry and N-xor-V polarities are reached. Several unused codes are included to exercise the illegal path.

// File: rtl/iu_alu_pkg.sv
// Shared definitions for the integer ALU.
// Assumes a 6-bit operation code; flag vector ordered {N,Z,V,C}.
package iu_alu_pkg;

    localparam int FLAG_N = 3;
    localparam int FLAG_Z = 2;
    localparam int FLAG_V = 1;
    localparam int FLAG_C = 0;

    typedef enum logic [5:0] {
        OP_ADD    = 6'h00, OP_AND    = 6'h01, OP_OR     = 6'h02, OP_XOR    = 6'h03,
        OP_SUB    = 6'h04, OP_ANDN   = 6'h05, OP_ORN    = 6'h06, OP_XNOR   = 6'h07,
        OP_ADDX   = 6'h08, OP_SUBX   = 6'h0C,
        OP_ADDCC  = 6'h10, OP_ANDCC  = 6'h11, OP_ORCC   = 6'h12, OP_XORCC  = 6'h13,
        OP_SUBCC  = 6'h14, OP_ANDNCC = 6'h15, OP_ORNCC  = 6'h16, OP_XNORCC = 6'h17,
        OP_ADDXCC = 6'h18, OP_SUBXCC = 6'h1C,
        OP_TADD   = 6'h20, OP_TADDTV = 6'h22, OP_MSTEP  = 6'h24,
        OP_SLL    = 6'h25, OP_SRL    = 6'h26, OP_SRA    = 6'h27
    } alu_op_e;

endpackage

// File: rtl/iu_alu_addsub.sv
// Shared adder/subtractor with carry handling and signed/unsigned
// condition outputs. Assumes the caller chooses the addends; carry into
// bit 0 is derived from sub_en, carry_en and c_flag.
module iu_alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub_en,
    input  logic         carry_en,
    input  logic         c_flag,
    output logic [W-1:0] sum,
    output logic         v_out,
    output logic         c_out
);
    logic [W-1:0] b_eff;
    logic         cin;
    logic [W-1:0] v_vec;
    logic [W-1:0] c_vec;

    // Select effective second addend and carry into bit 0
    always_comb begin
        b_eff = sub_en ? ~b : b;
        if (sub_en) cin = carry_en ? ~c_flag : 1'b1;
        else        cin = carry_en ?  c_flag : 1'b0;
    end

    // Single carry-propagate adder shared by all arithmetic operations
    always_comb sum = a + b_eff + {{(W-1){1'b0}}, cin};

    // Overflow and carry/borrow from operand and result sign patterns
    always_comb begin
        if (sub_en) begin
            v_vec = (a & ~b & ~sum) | (~a & b & sum);
            c_vec = (~a & b) | ((~a | b) & sum);
        end else begin
            v_vec = (a & b & ~sum) | (~a & ~b & sum);
            c_vec = (a & b) | ((a | b) & ~sum);
        end
        v_out = v_vec[W-1];
        c_out = c_vec[W-1];
    end

    // Cross-check flags against signed/unsigned arithmetic views
    always_comb begin
        if (!sub_en) begin
            a_r3_add_overflow: assert (v_out ==
                ((a[W-1] == b[W-1]) && (sum[W-1] != a[W-1])));
            a_r3_add_carry: assert (c_out ==
                (({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin}) > {1'b0, {W{1'b1}}}));
        end else begin
            a_r4_sub_overflow: assert (v_out ==
                ((a[W-1] != b[W-1]) && (sum[W-1] != a[W-1])));
            a_r4_sub_borrow: assert (c_out ==
                ({1'b0, a} < ({1'b0, b} + {{W{1'b0}}, carry_en & c_flag})));
        end
    end
endmodule

// File: rtl/iu_alu_logic.sv
// Bitwise logic unit: and, or, xor, each optionally with the second
// operand inverted. Assumes sel[1:0] is 1, 2 or 3 when used.
module iu_alu_logic #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [2:0]   sel,
    output logic [W-1:0] res
);
    logic [W-1:0] b_eff;

    // Apply optional inversion then pick the boolean function
    always_comb begin
        b_eff = sel[2] ? ~b : b;
        case (sel[1:0])
            2'd1:    res = a & b_eff;
            2'd2:    res = a | b_eff;
            2'd3:    res = a ^ b_eff;
            default: res = '0;
        endcase
    end

    // Inverted forms must match their algebraic definitions
    always_comb begin
        if (sel == 3'd7) a_r5_xnor_form: assert (res == ~(a ^ b));
        if (sel == 3'd5) a_r5_andn_form: assert ((res & b) == '0);
    end
endmodule

// File: rtl/iu_alu_shift.sv
// Logarithmic barrel shifter. Left shifts reuse the right-shift stages
// through bit reversal. Assumes arith is only set for right shifts.
module iu_alu_shift #(
    parameter int W = 32
) (
    input  logic [W-1:0]          a,
    input  logic [$clog2(W)-1:0]  amt,
    input  logic                  left,
    input  logic                  arith,
    output logic [W-1:0]          res
);
    localparam int SHW = $clog2(W);

    logic [W-1:0] rev_in;
    logic [W-1:0] rev_out;
    logic [W-1:0] stage [0:SHW];
    logic         fill;

    // Reverse bit order in and out for left shifts
    for (genvar i = 0; i < W; i++) begin : g_rev
        assign rev_in[i]  = a[W-1-i];
        assign rev_out[i] = stage[SHW][W-1-i];
    end

    // Sign fill only for arithmetic right shifts
    always_comb fill = arith & ~left & a[W-1];

    assign stage[0] = left ? rev_in : a;

    // One conditional right shift by 2^k per stage
    for (genvar k = 0; k < SHW; k++) begin : g_stage
        assign stage[k+1] = amt[k]
            ? {{(1 << k){fill}}, stage[k][W-1:(1 << k)]}
            : stage[k];
    end

    // Final orientation
    always_comb res = left ? rev_out : stage[SHW];

    // Compare against language shift operators
    always_comb begin
        if (left)       a_r9_left_shift:  assert (res == (a << amt));
        else if (arith) a_r9_arith_shift: assert (res == W'($signed(a) >>> amt));
        else            a_r9_right_shift: assert (res == (a >> amt));
    end
endmodule

// File: rtl/iu_alu.sv
// Combinational integer ALU: decodes the operation code, steers operands
// into the shared adder, logic unit and shifter, and forms the result,
// next flags, next Y and strobes. Assumes inputs are settled each cycle;
// state is held by the surrounding pipeline.
module iu_alu #(
    parameter int W     = 32,
    parameter int TAG_W = 2
) (
    input  logic [5:0]   opcode,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [3:0]   flags_in,
    input  logic [W-1:0] y_in,
    output logic [W-1:0] result,
    output logic [3:0]   flags_out,
    output logic         flags_we,
    output logic         tag_trap,
    output logic [W-1:0] y_out,
    output logic         y_we,
    output logic         illegal
);
    import iu_alu_pkg::*;

    localparam int SHW = $clog2(W);

    alu_op_e      op;
    logic         is_sub;
    logic         use_carry;
    logic         is_mstep;
    logic [W-1:0] add_a;
    logic [W-1:0] add_b;
    logic [W-1:0] sum;
    logic         add_v;
    logic         add_c;
    logic [W-1:0] logic_res;
    logic [W-1:0] shift_res;
    logic         shift_left;
    logic         shift_arith;
    logic         tag_bad;
    logic [3:0]   cc_new;

    assign op = alu_op_e'(opcode);

    // Adder steering: subtract, carry use and multiply-step operand build
    always_comb begin
        is_sub    = (op == OP_SUB) || (op == OP_SUBCC) || (op == OP_SUBX) || (op == OP_SUBXCC);
        use_carry = (op == OP_ADDX) || (op == OP_ADDXCC) || (op == OP_SUBX) || (op == OP_SUBXCC);
        is_mstep  = (op == OP_MSTEP);
        add_a     = is_mstep ? {flags_in[FLAG_N] ^ flags_in[FLAG_V], op_a[W-1:1]} : op_a;
        add_b     = (is_mstep && !y_in[0]) ? '0 : op_b;
    end

    // Tag bits of either operand nonzero
    always_comb tag_bad = |(op_a[TAG_W-1:0] | op_b[TAG_W-1:0]);

    // Shift direction and kind
    always_comb begin
        shift_left  = (op == OP_SLL);
        shift_arith = (op == OP_SRA);
    end

    iu_alu_addsub #(.W(W)) u_addsub (
        .a        (add_a),
        .b        (add_b),
        .sub_en   (is_sub),
        .carry_en (use_carry),
        .c_flag   (flags_in[FLAG_C]),
        .sum      (sum),
        .v_out    (add_v),
        .c_out    (add_c)
    );

    iu_alu_logic #(.W(W)) u_logic (
        .a   (op_a),
        .b   (op_b),
        .sel (opcode[2:0]),
        .res (logic_res)
    );

    iu_alu_shift #(.W(W)) u_shift (
        .a     (op_a),
        .amt   (op_b[SHW-1:0]),
        .left  (shift_left),
        .arith (shift_arith),
        .res   (shift_res)
    );

    // Operation decode: result select, new flags and strobes
    always_comb begin
        result   = '0;
        cc_new   = flags_in;
        flags_we = 1'b0;
        tag_trap = 1'b0;
        y_out    = y_in;
        y_we     = 1'b0;
        illegal  = 1'b0;
        case (op)
            OP_ADD, OP_SUB, OP_ADDX, OP_SUBX: begin
                result = sum;
            end
            OP_ADDCC, OP_SUBCC, OP_ADDXCC, OP_SUBXCC: begin
                result   = sum;
                flags_we = 1'b1;
                cc_new   = {sum[W-1], sum == '0, add_v, add_c};
            end
            OP_AND, OP_OR, OP_XOR, OP_ANDN, OP_ORN, OP_XNOR: begin
                result = logic_res;
            end
            OP_ANDCC, OP_ORCC, OP_XORCC, OP_ANDNCC, OP_ORNCC, OP_XNORCC: begin
                result   = logic_res;
                flags_we = 1'b1;
                cc_new   = {logic_res[W-1], logic_res == '0, 2'b00};
            end
            OP_TADD: begin
                result   = sum;
                flags_we = 1'b1;
                cc_new   = {sum[W-1], sum == '0, add_v | tag_bad, add_c};
            end
            OP_TADDTV: begin
                result = sum;
                if (add_v || tag_bad) begin
                    tag_trap = 1'b1;
                end else begin
                    flags_we = 1'b1;
                    cc_new   = {sum[W-1], sum == '0, 1'b0, add_c};
                end
            end
            OP_MSTEP: begin
                result   = sum;
                flags_we = 1'b1;
                cc_new   = {sum[W-1], sum == '0, add_v, add_c};
                y_we     = 1'b1;
                y_out    = {op_a[0], y_in[W-1:1]};
            end
            OP_SLL, OP_SRL, OP_SRA: begin
                result = shift_res;
            end
            default: begin
                illegal = 1'b1;
            end
        endcase
    end

    // Flags pass through unless written
    always_comb flags_out = flags_we ? cc_new : flags_in;

    // Port-level relations between result, flags and strobes
    always_comb begin
        if (flags_we) begin
            a_r2_n_tracks_msb: assert (flags_out[FLAG_N] == result[W-1]);
            a_r2_z_on_zero:    assert (flags_out[FLAG_Z] == (result == '0));
        end else begin
            a_r6_flags_hold:   assert (flags_out == flags_in);
        end
        if (tag_trap) a_r8_trap_blocks_write: assert (!flags_we && flags_out == flags_in);
        if (!y_we)    a_r11_y_hold:           assert (y_out == y_in);
        if (illegal)  a_r12_illegal_quiet:    assert (!flags_we && !y_we && !tag_trap && result == '0);
        a_r12_trap_illegal_excl: assert ($onehot0({tag_trap, illegal}));
    end
endmodule

// File: tb/iu_alu_tb.sv
// Self-checking bench: seeded random and corner operands for every
// operation code, compared against a bench reference model.
module iu_alu_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  opcode = '0;
    logic [31:0] op_a = '0, op_b = '0, y_in = '0;
    logic [3:0]  flags_in = '0;
    logic [31:0] result, y_out;
    logic [3:0]  flags_out;
    logic        flags_we, tag_trap, y_we, illegal;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    iu_alu u_dut (
        .opcode(opcode), .op_a(op_a), .op_b(op_b), .flags_in(flags_in), .y_in(y_in),
        .result(result), .flags_out(flags_out), .flags_we(flags_we), .tag_trap(tag_trap),
        .y_out(y_out), .y_we(y_we), .illegal(illegal)
    );

    localparam logic [5:0] OPS [30] = '{
        6'h00, 6'h01, 6'h02, 6'h03, 6'h04, 6'h05, 6'h06, 6'h07, 6'h08, 6'h0C,
        6'h10, 6'h11, 6'h12, 6'h13, 6'h14, 6'h15, 6'h16, 6'h17, 6'h18, 6'h1C,
        6'h20, 6'h22, 6'h24, 6'h25, 6'h26, 6'h27, 6'h09, 6'h21, 6'h28, 6'h3F
    };
    localparam logic [31:0] CORNER [4] = '{32'h0, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF};

    // Reference model: {result, flags, flags_we, trap, y, y_we, illegal}
    function automatic logic [71:0] ref_model(input logic [5:0] op, input logic [31:0] a,
                                              input logic [31:0] b, input logic [31:0] y,
                                              input logic [3:0] f);
        logic [32:0] w;
        logic [31:0] r, y2, p, q;
        logic [3:0]  fo;
        logic        we, tr, ywe, ill, v, c, tagb, sets, arith, sub;
        r = '0; fo = f; we = 0; tr = 0; y2 = y; ywe = 0; ill = 0; sets = 0; arith = 0; sub = 0;
        v = 0; c = 0; w = '0;
        tagb = (a[1:0] != 2'b00) || (b[1:0] != 2'b00);
        p = a; q = b;
        case (op)
            6'h00, 6'h10, 6'h08, 6'h18, 6'h20, 6'h22, 6'h24: begin
                if (op == 6'h24) begin
                    p = {f[3] ^ f[1], a[31:1]};
                    q = y[0] ? b : 32'h0;
                end
                w = {1'b0, p} + {1'b0, q} + ((op == 6'h08 || op == 6'h18) ? 33'(f[0]) : 33'd0);
                arith = 1;
            end
            6'h04, 6'h14, 6'h0C, 6'h1C: begin
                w = {1'b0, a} - {1'b0, b} - ((op[3]) ? 33'(f[0]) : 33'd0);
                arith = 1; sub = 1;
            end
            6'h01, 6'h11: r = a & b;
            6'h02, 6'h12: r = a | b;
            6'h03, 6'h13: r = a ^ b;
            6'h05, 6'h15: r = a & ~b;
            6'h06, 6'h16: r = a | ~b;
            6'h07, 6'h17: r = ~(a ^ b);
            6'h25: r = a << b[4:0];
            6'h26: r = a >> b[4:0];
            6'h27: r = $signed(a) >>> b[4:0];
            default: ill = 1;
        endcase
        if (arith) begin
            r = w[31:0];
            c = w[32];
            if (sub) v = (p[31] != q[31]) && (r[31] != p[31]);
            else     v = (p[31] == q[31]) && (r[31] != p[31]);
            if (op[4] || op == 6'h24) sets = 1;
            if (op == 6'h20) begin sets = 1; v = v | tagb; end
            if (op == 6'h22) begin
                if (v || tagb) tr = 1;
                else begin sets = 1; v = 0; end
            end
            if (op == 6'h24) begin ywe = 1; y2 = {a[0], y[31:1]}; end
        end else if (!ill && op[4] && op[5] == 1'b0) begin
            sets = 1;
        end
        if (sets) begin we = 1; fo = {r[31], r == 32'h0, v, c}; end
        return {r, fo, we, tr, y2, ywe, ill};
    endfunction

    function automatic string req_of(input logic [5:0] op);
        case (op)
            6'h00, 6'h04, 6'h08, 6'h0C:        return "R1/R6/R11";
            6'h10, 6'h18:                      return "R1/R2/R3";
            6'h14, 6'h1C:                      return "R1/R2/R4";
            6'h01, 6'h02, 6'h03, 6'h05, 6'h06, 6'h07: return "R5/R6";
            6'h11, 6'h12, 6'h13, 6'h15, 6'h16, 6'h17: return "R5/R2";
            6'h20:                             return "R7/R3";
            6'h22:                             return "R8";
            6'h24:                             return "R10/R11";
            6'h25, 6'h26, 6'h27:               return "R9/R6";
            default:                           return "R12";
        endcase
    endfunction

    // Drive one vector after a rising edge, compare at the falling edge
    task automatic apply(input logic [5:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] y, input logic [3:0] f, input string tag);
        logic [71:0] exp_v, act_v;
        @(posedge clk);
        #1;
        opcode = op; op_a = a; op_b = b; y_in = y; flags_in = f;
        @(negedge clk);
        exp_v = ref_model(op, a, b, y, f);
        act_v = {result, flags_out, flags_we, tag_trap, y_out, y_we, illegal};
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s op=%h a=%h b=%h: actual=%h expected=%h", tag, op, a, b, act_v, exp_v);
        end
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'h5EED_1234);
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Quiescent state after reset: add of zeros, nothing written (R6)
        apply(6'h00, 32'h0, 32'h0, 32'h0, 4'h0, "R6");
        // Directed: equal subtract gives Z, C clear (R2, R4)
        apply(6'h14, 32'h1234_5678, 32'h1234_5678, 32'h0, 4'h0, "R2/R4");
        // Directed: subtract with carry borrows (R1)
        apply(6'h1C, 32'h0, 32'h0, 32'h0, 4'h1, "R1/R4");
        // Directed: tag bits force trap and hold flags (R8)
        apply(6'h22, 32'h0000_0004, 32'h0000_0001, 32'h0, 4'hA, "R8");
        // Directed: clean tagged add writes flags (R8)
        apply(6'h22, 32'h0000_0004, 32'h0000_0008, 32'h0, 4'hF, "R8");
        // Directed: tagged add overflow traps (R8)
        apply(6'h22, 32'h7FFF_FFFC, 32'h0000_0004, 32'h0, 4'h5, "R8");
        // Directed: tagged add flags V on tag bits (R7)
        apply(6'h20, 32'h0000_0002, 32'h0000_0004, 32'h0, 4'h0, "R7");
        // Directed: shift count ignores b[31:5] (R9)
        apply(6'h25, 32'h0000_0001, 32'hFFFF_FFE3, 32'h0, 4'h0, "R9");
        apply(6'h27, 32'h8000_0000, 32'h0000_003F, 32'h0, 4'h0, "R9");
        // Directed: multiply step with Y[0]=0 and N^V=1 (R10, R11)
        apply(6'h24, 32'h0000_0003, 32'hFFFF_FFFF, 32'h0000_0002, 4'h8, "R10/R11");
        apply(6'h24, 32'h0000_0002, 32'h0000_0005, 32'h0000_0001, 4'h2, "R10/R11");
        // Directed: illegal code (R12)
        apply(6'h3F, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h1, 4'h3, "R12");
        // Corner pairings for every code
        for (int oi = 0; oi < 30; oi++) begin
            for (int ai = 0; ai < 4; ai++) begin
                for (int bi = 0; bi < 4; bi++) begin
                    apply(OPS[oi], CORNER[ai], CORNER[bi], $urandom, 4'($urandom),
                          req_of(OPS[oi]));
                end
            end
        end
        // Random operands for every code
        for (int oi = 0; oi < 30; oi++) begin
            for (int n = 0; n < 100; n++) begin
                apply(OPS[oi], $urandom, $urandom, $urandom, 4'($urandom), req_of(OPS[oi]));
            end
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule